// File: doc/BRIEF.md
# DDR SDRAM Command Front End

This block sits between a memory controller's command pins and the downstream engines of a DDR SDRAM model or protocol monitor. On every rising clock edge it samples chip select, row strobe, column strobe, write enable, a bank number and the address bus. From these it decodes one command, checks it against the state of the four banks and the write burst in flight, and emits one registered indication pulse per accepted command.

Each bank has an open/closed flag and an open-row register. Reads and writes are checked against these and report the row that is open in the addressed bank. A mode register, loaded from the address bus by a mode-set command, fixes the burst length, burst ordering and read latency. The burst length also sets how long a write burst occupies the data path. A read that would cut into that burst is refused and flagged. All indications and error flags appear in the clock cycle after the edge that sampled the command.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset, all banks are closed, no indication or error output is high, `wr_busy_o` is low, and the mode outputs read burst length 4, sequential ordering, read latency 3.
- R2: With `cke_i` high and `cs_n_i` low, the pins {ras_n, cas_n, we_n} decode as follows: 011 is activate, 101 is read, 100 is write, 010 is precharge, 001 is refresh, 000 is mode set, and 111 and 110 are no-op. At most one of `act_o`, `rd_o`, `wr_o`, `pre_o` and `ref_o` is high, for one cycle, in the cycle after the sampling edge.
- R3: When `cs_n_i` is high or `cke_i` is low at an edge, the command is ignored. No indication or error is raised and no bank or mode state changes, but a write burst already running keeps counting down.
- R4: An activate marks the addressed bank open and stores the full 12-bit address as its row. Banks are tracked independently. An accepted read or write reports the stored row of its bank on `cmd_row_o`, and activate reports the new row there. `cmd_bank_o` gives the bank of every activate, read, write and single-bank precharge, and of every rejected read or write.
- R5: A read or write to a closed bank is not issued. Instead `err_closed_o` pulses, and bank state does not change.
- R6: A precharge with address bit 10 high closes every bank and raises `pre_all_o` with `pre_o`. With bit 10 low it closes only the addressed bank.
- R7: An accepted read or write with address bit 8 high raises `auto_pre_o` alongside `rd_o`/`wr_o`, and the bank is closed from that edge on.
- R8: A mode set loads address bits [2:0] as the burst code (1=2 beats, 2=4, 3=8, 7=full page of 256 beats), bit 3 as the ordering (1 = interleaved), and bits [6:4] as the read latency. The result appears on `burst_len_o`, `burst_il_o` and `rd_lat_o` after the edge.
- R9: A mode set is ignored and the register keeps its value if the latency field is not 3, if the burst code is not 1, 2, 3 or 7, or if a full-page length is combined with interleaved ordering.
- R10: An accepted write keeps `wr_busy_o` high for the burst length divided by two following edges, with two beats per clock. The count covers edges where commands are ignored.
- R11: A read to an open bank at an edge where `wr_busy_o` is high is not issued. `err_intr_o` pulses, and no auto-precharge takes effect. A read to a closed bank reports only `err_closed_o`.
- R12: A write accepted while `wr_busy_o` is high restarts the burst count from the full length.
- R13: An accepted read or write reports address bits [7:0] on `cmd_col_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock enable, low blocks new commands |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| bank_i | input | 2 | Bank number |
| addr_i | input | 12 | Row, column, flags or mode value |
| act_o | output | 1 | Activate issued |
| rd_o | output | 1 | Read issued |
| wr_o | output | 1 | Write issued |
| pre_o | output | 1 | Precharge issued |
| ref_o | output | 1 | Refresh issued |
| pre_all_o | output | 1 | Precharge applied to all banks |
| auto_pre_o | output | 1 | Issued read or write closes its bank |
| cmd_bank_o | output | 2 | Bank of the last decoded command |
| cmd_row_o | output | 12 | Row of the last activate, read or write |
| cmd_col_o | output | 8 | Column of the last read or write |
| err_closed_o | output | 1 | Read or write refused, bank closed |
| err_intr_o | output | 1 | Read refused, write burst running |
| bank_open_o | output | 4 | Open flag per bank |
| wr_busy_o | output | 1 | Write burst in progress |
| burst_len_o | output | 9 | Programmed burst length in beats |
| burst_il_o | output | 1 | Interleaved ordering selected |
| rd_lat_o | output | 3 | Programmed read latency in clocks |

## Verification
The hardest state to reach from the pins is a read that lands on the last edge of a write burst, or just past it. To get there, the bench needs a bank already open, a chosen burst length and a write, and then the edges must be counted exactly. Directed sequences program 8-beat bursts and place reads on every edge of the window. They also interleave deselected edges and a restarting write inside it. Seeded random traffic then mixes activates, precharges and legal and illegal mode values so that reads and writes meet open, closed and busy banks in many orders. Every cycle is compared against a bench model of banks, mode and burst count.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF,
      CMD_MRS
   } cmd_e;

   localparam int unsigned LAT_SUPPORTED = 3;

   // strobe pins, active low, to command
   function automatic cmd_e pins_to_cmd(input logic ras_n, input logic cas_n,
                                        input logic we_n);
      cmd_e c;
      case ({ras_n, cas_n, we_n})
         3'b011:  c = CMD_ACT;
         3'b101:  c = CMD_RD;
         3'b100:  c = CMD_WR;
         3'b010:  c = CMD_PRE;
         3'b001:  c = CMD_REF;
         3'b000:  c = CMD_MRS;
         default: c = CMD_NOP;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sdram_cmd_dec.sv
module sdram_cmd_dec
   import sdram_cmd_pkg::*;
(
   input  logic cke_i,
   input  logic cs_n_i,
   input  logic ras_n_i,
   input  logic cas_n_i,
   input  logic we_n_i,
   output cmd_e cmd_o
);

   always_comb begin
      if (!cke_i || cs_n_i) cmd_o = CMD_NOP;
      else                  cmd_o = pins_to_cmd(ras_n_i, cas_n_i, we_n_i);
   end

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BANK_W-1:0]    bank_i,
   input  logic [ROW_W-1:0]     row_i,
   input  logic                 open_i,
   input  logic                 close_i,
   input  logic                 close_all_i,
   output logic [NUM_BANKS-1:0] open_o,
   output logic [ROW_W-1:0]     row_o
);

   logic [ROW_W-1:0] row_q [NUM_BANKS];

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic hit;
      assign hit = (bank_i == BANK_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_o[g] <= 1'b0;
            row_q[g]  <= '0;
         end else if (open_i && hit) begin
            open_o[g] <= 1'b1;
            row_q[g]  <= row_i;
         end else if (close_all_i || (close_i && hit)) begin
            open_o[g] <= 1'b0;
         end
      end
   end

   assign row_o = row_q[bank_i];

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
   import sdram_cmd_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [6:0]       fld_i,
   output logic [COL_W:0]   beats_o,
   output logic [COL_W-1:0] half_o,
   output logic             il_o,
   output logic [2:0]       lat_o
);

   logic [2:0] code_q;
   logic       legal;
   logic       len_ok;

   always_comb begin
      case (fld_i[2:0])
         3'd1, 3'd2, 3'd3: len_ok = 1'b1;
         3'd7:             len_ok = !fld_i[3];
         default:          len_ok = 1'b0;
      endcase
      legal = len_ok && (fld_i[6:4] == 3'(LAT_SUPPORTED));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= 3'd2;
         il_o   <= 1'b0;
         lat_o  <= 3'(LAT_SUPPORTED);
      end else if (load_i && legal) begin
         code_q <= fld_i[2:0];
         il_o   <= fld_i[3];
         lat_o  <= fld_i[6:4];
      end
   end

   always_comb begin
      case (code_q)
         3'd1:    beats_o = (COL_W+1)'(2);
         3'd3:    beats_o = (COL_W+1)'(8);
         3'd7:    beats_o = (COL_W+1)'(1) << COL_W;
         default: beats_o = (COL_W+1)'(4);
      endcase
   end

   assign half_o = beats_o[COL_W:1];

endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_i)        cnt_q <= len_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
   import sdram_cmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = $clog2(NUM_BANKS),
   parameter int ADDR_W    = 12,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 8,
   parameter int AP_BIT    = 8,
   parameter int ALL_BIT   = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke_i,
   input  logic                 cs_n_i,
   input  logic                 ras_n_i,
   input  logic                 cas_n_i,
   input  logic                 we_n_i,
   input  logic [BANK_W-1:0]    bank_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic                 act_o,
   output logic                 rd_o,
   output logic                 wr_o,
   output logic                 pre_o,
   output logic                 ref_o,
   output logic                 pre_all_o,
   output logic                 auto_pre_o,
   output logic [BANK_W-1:0]    cmd_bank_o,
   output logic [ROW_W-1:0]     cmd_row_o,
   output logic [COL_W-1:0]     cmd_col_o,
   output logic                 err_closed_o,
   output logic                 err_intr_o,
   output logic [NUM_BANKS-1:0] bank_open_o,
   output logic                 wr_busy_o,
   output logic [COL_W:0]       burst_len_o,
   output logic                 burst_il_o,
   output logic [2:0]           rd_lat_o
);

   // elaboration checks
   if (ROW_W != ADDR_W) begin : g_bad_row
      $error("ROW_W must equal ADDR_W");
   end
   if (COL_W > AP_BIT || AP_BIT >= ADDR_W || ALL_BIT >= ADDR_W) begin : g_bad_flag
      $error("flag bits must sit above the column and inside the address");
   end
   if (ADDR_W < 7 || COL_W < 3) begin : g_bad_mode
      $error("address too narrow for mode fields or burst of 8");
   end
   if ((1 << BANK_W) < NUM_BANKS) begin : g_bad_bank
      $error("BANK_W too small for NUM_BANKS");
   end

   cmd_e             cmd;
   logic [ROW_W-1:0] open_row;
   logic [COL_W-1:0] half_len;
   logic             tgt_open;
   logic             rd_go, wr_go, rej_closed, rej_intr;
   logic             ap_req, all_req;

   sdram_cmd_dec u_dec (
      .cke_i   (cke_i),
      .cs_n_i  (cs_n_i),
      .ras_n_i (ras_n_i),
      .cas_n_i (cas_n_i),
      .we_n_i  (we_n_i),
      .cmd_o   (cmd)
   );

   assign tgt_open   = bank_open_o[bank_i];
   assign ap_req     = addr_i[AP_BIT];
   assign all_req    = addr_i[ALL_BIT];
   assign rej_closed = (cmd == CMD_RD || cmd == CMD_WR) && !tgt_open;
   assign rej_intr   = (cmd == CMD_RD) && tgt_open && wr_busy_o;
   assign rd_go      = (cmd == CMD_RD) && tgt_open && !wr_busy_o;
   assign wr_go      = (cmd == CMD_WR) && tgt_open;

   sdram_bank_table #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .ROW_W     (ROW_W)
   ) u_banks (
      .clk         (clk),
      .rst_n       (rst_n),
      .bank_i      (bank_i),
      .row_i       (addr_i[ROW_W-1:0]),
      .open_i      (cmd == CMD_ACT),
      .close_i     (((rd_go || wr_go) && ap_req) || (cmd == CMD_PRE && !all_req)),
      .close_all_i (cmd == CMD_PRE && all_req),
      .open_o      (bank_open_o),
      .row_o       (open_row)
   );

   sdram_mode_reg #(
      .COL_W (COL_W)
   ) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (cmd == CMD_MRS),
      .fld_i   (addr_i[6:0]),
      .beats_o (burst_len_o),
      .half_o  (half_len),
      .il_o    (burst_il_o),
      .lat_o   (rd_lat_o)
   );

   sdram_wr_burst #(
      .CNT_W (COL_W)
   ) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (wr_go),
      .len_i   (half_len),
      .busy_o  (wr_busy_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_o        <= 1'b0;
         rd_o         <= 1'b0;
         wr_o         <= 1'b0;
         pre_o        <= 1'b0;
         ref_o        <= 1'b0;
         pre_all_o    <= 1'b0;
         auto_pre_o   <= 1'b0;
         err_closed_o <= 1'b0;
         err_intr_o   <= 1'b0;
         cmd_bank_o   <= '0;
         cmd_row_o    <= '0;
         cmd_col_o    <= '0;
      end else begin
         act_o        <= (cmd == CMD_ACT);
         rd_o         <= rd_go;
         wr_o         <= wr_go;
         pre_o        <= (cmd == CMD_PRE);
         ref_o        <= (cmd == CMD_REF);
         pre_all_o    <= (cmd == CMD_PRE) && all_req;
         auto_pre_o   <= (rd_go || wr_go) && ap_req;
         err_closed_o <= rej_closed;
         err_intr_o   <= rej_intr;
         if (cmd != CMD_NOP) begin
            cmd_bank_o <= bank_i;
            cmd_row_o  <= (cmd == CMD_ACT) ? addr_i[ROW_W-1:0] : open_row;
            cmd_col_o  <= addr_i[COL_W-1:0];
         end
      end
   end

endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int ADDR_W    = 12,
   parameter int COL_W     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cke_i,
   input logic                 cs_n_i,
   input logic [BANK_W-1:0]    bank_i,
   input logic                 act_o,
   input logic                 rd_o,
   input logic                 wr_o,
   input logic                 pre_o,
   input logic                 ref_o,
   input logic                 auto_pre_o,
   input logic [BANK_W-1:0]    cmd_bank_o,
   input logic                 err_closed_o,
   input logic                 err_intr_o,
   input logic [NUM_BANKS-1:0] bank_open_o,
   input logic                 wr_busy_o,
   input logic [COL_W:0]       burst_len_o,
   input logic                 burst_il_o,
   input logic [2:0]           rd_lat_o
);

   localparam logic [COL_W:0] FULL_PAGE = (COL_W+1)'(1) << COL_W;

   AST_ONE_INDICATION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act_o, rd_o, wr_o, pre_o, ref_o})); // R2

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cke_i || cs_n_i) |->
         !(act_o || rd_o || wr_o || pre_o || ref_o || err_closed_o || err_intr_o)); // R3

   AST_ISSUE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_o || wr_o) |-> $past(bank_open_o[bank_i])); // R4

   AST_CLOSED_NOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
      err_closed_o |-> !(rd_o || wr_o || err_intr_o)); // R5

   AST_AUTO_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_o || wr_o) && auto_pre_o) |-> !bank_open_o[cmd_bank_o]); // R7

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lat_o == 3'd3) && !(burst_il_o && burst_len_o == FULL_PAGE) &&
      (burst_len_o == 2 || burst_len_o == 4 || burst_len_o == 8 ||
       burst_len_o == FULL_PAGE)); // R9

   AST_BURST_RUNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy_o) |-> $past(!wr_busy_o) && wr_o); // R10

   AST_NO_READ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      rd_o |-> !$past(wr_busy_o)); // R11

endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W),
   .ADDR_W    (ADDR_W),
   .COL_W     (COL_W)
) i_chk (.*);

// File: tb/test_sdram_cmd_front.sv
module test_sdram_cmd_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke_i = 1'b1, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
   logic [1:0]  bank_i = '0;
   logic [11:0] addr_i = '0;
   logic        act_o, rd_o, wr_o, pre_o, ref_o, pre_all_o, auto_pre_o;
   logic [1:0]  cmd_bank_o;
   logic [11:0] cmd_row_o;
   logic [7:0]  cmd_col_o;
   logic        err_closed_o, err_intr_o;
   logic [3:0]  bank_open_o;
   logic        wr_busy_o;
   logic [8:0]  burst_len_o;
   logic        burst_il_o;
   logic [2:0]  rd_lat_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // bench model
   bit         m_open [4];
   bit [11:0]  m_row  [4];
   bit [2:0]   m_code;
   bit         m_il;
   int         m_cnt;

   always #4 clk = ~clk;

   sdram_cmd_front i_sdram_cmd_front (
      .clk, .rst_n, .cke_i, .cs_n_i, .ras_n_i, .cas_n_i, .we_n_i, .bank_i, .addr_i,
      .act_o, .rd_o, .wr_o, .pre_o, .ref_o, .pre_all_o, .auto_pre_o,
      .cmd_bank_o, .cmd_row_o, .cmd_col_o, .err_closed_o, .err_intr_o,
      .bank_open_o, .wr_busy_o, .burst_len_o, .burst_il_o, .rd_lat_o
   );

   function automatic int beats_of(input bit [2:0] c);
      case (c)
         3'd1: return 2;
         3'd3: return 8;
         3'd7: return 256;
         default: return 4;
      endcase
   endfunction

   function automatic bit mode_ok(input bit [6:0] f);
      if (f[6:4] != 3'd3) return 0;
      if (f[2:0] == 3'd7) return !f[3];
      return (f[2:0] >= 3'd1 && f[2:0] <= 3'd3);
   endfunction

   task automatic chk(input string tag, input string what, input int got, input int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // k: 0 nop,1 act,2 rd,3 wr,4 pre,5 ref,6 mrs
   function automatic int kind_of(input bit cke, input bit cs_n, input bit [2:0] p);
      if (!cke || cs_n) return 0;
      case (p)
         3'b011: return 1;
         3'b101: return 2;
         3'b100: return 3;
         3'b010: return 4;
         3'b001: return 5;
         3'b000: return 6;
         default: return 0;
      endcase
   endfunction

   task automatic step(input bit cke, input bit cs_n, input bit [2:0] p,
                       input bit [1:0] ba, input bit [11:0] ad);
      int    k;
      bit    e_act, e_rd, e_wr, e_pre, e_ref, e_all, e_ap, e_ecl, e_eint;
      bit [11:0] e_row;
      string tag, stag;
      bit    restart;
      @(negedge clk);
      cke_i = cke; cs_n_i = cs_n; {ras_n_i, cas_n_i, we_n_i} = p; bank_i = ba; addr_i = ad;
      k = kind_of(cke, cs_n, p);
      {e_act, e_rd, e_wr, e_pre, e_ref, e_all, e_ap, e_ecl, e_eint} = '0;
      e_row = (k == 1) ? ad : m_row[ba];
      restart = 0;
      tag  = (!cke || cs_n) ? "R3" : "R2";
      stag = tag;
      case (k)
         1: begin e_act = 1; tag = "R4"; end
         2, 3: begin
            if (!m_open[ba]) begin e_ecl = 1; tag = "R5"; end
            else if (k == 2 && m_cnt != 0) begin e_eint = 1; tag = "R11"; end
            else begin
               e_rd = (k == 2); e_wr = (k == 3); e_ap = ad[8];
               tag = ad[8] ? "R7" : "R13";
            end
         end
         4: begin e_pre = 1; e_all = ad[10]; tag = "R6"; end
         5: e_ref = 1;
         default: ;
      endcase
      stag = tag;
      // model update
      if (e_wr) begin restart = (m_cnt != 0); m_cnt = beats_of(m_code) / 2; end
      else if (m_cnt != 0) m_cnt--;
      if (k == 1) begin m_open[ba] = 1; m_row[ba] = ad; end
      if ((e_rd || e_wr) && ad[8]) m_open[ba] = 0;
      if (k == 4) begin
         if (ad[10]) for (int b = 0; b < 4; b++) m_open[b] = 0;
         else m_open[ba] = 0;
      end
      if (k == 6) begin
         stag = mode_ok(ad[6:0]) ? "R8" : "R9";
         if (mode_ok(ad[6:0])) begin m_code = ad[2:0]; m_il = ad[3]; end
      end
      @(posedge clk);
      #1;
      chk(tag, "indications", int'({act_o, rd_o, wr_o, pre_o, ref_o, pre_all_o,
                                    auto_pre_o, err_closed_o, err_intr_o}),
          int'({e_act, e_rd, e_wr, e_pre, e_ref, e_all, e_ap, e_ecl, e_eint}));
      chk(tag, "bank_open", int'(bank_open_o),
          int'({m_open[3], m_open[2], m_open[1], m_open[0]}));
      chk(restart ? "R12" : "R10", "wr_busy", int'(wr_busy_o), int'(m_cnt != 0));
      if (e_act || e_rd || e_wr) chk("R4", "cmd_row", int'(cmd_row_o), int'(e_row));
      if (e_act || e_rd || e_wr || e_ecl || e_eint || (e_pre && !e_all))
         chk("R4", "cmd_bank", int'(cmd_bank_o), int'(ba));
      if (e_rd || e_wr) chk("R13", "cmd_col", int'(cmd_col_o), int'(ad[7:0]));
      if (k == 6 || tag == "R3") begin
         chk(stag, "burst_len", int'(burst_len_o), beats_of(m_code));
         chk(stag, "burst_il", int'(burst_il_o), int'(m_il));
         chk(stag, "rd_lat", int'(rd_lat_o), 3);
      end
   endtask

   localparam bit [2:0] P_NOP = 3'b111, P_BST = 3'b110, P_ACT = 3'b011, P_RD = 3'b101,
                        P_WR = 3'b100, P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000;

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      bit [11:0] mv [6];
      void'($urandom(32'h5EED_0D0E));
      for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = '0; end
      m_code = 3'd2; m_il = 0; m_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "indications", int'({act_o, rd_o, wr_o, pre_o, ref_o, pre_all_o,
                                     auto_pre_o, err_closed_o, err_intr_o}), 0);
      chk("R1", "bank_open", int'(bank_open_o), 0);
      chk("R1", "wr_busy", int'(wr_busy_o), 0);
      chk("R1", "burst_len", int'(burst_len_o), 4);
      chk("R1", "burst_il", int'(burst_il_o), 0);
      chk("R1", "rd_lat", int'(rd_lat_o), 3);

      // R2 no-op codes
      step(1, 0, P_NOP, 2'd0, 12'h000);
      step(1, 0, P_BST, 2'd1, 12'h000);
      step(1, 0, P_REF, 2'd0, 12'h000);
      // R4 activates
      step(1, 0, P_ACT, 2'd0, 12'hABC);
      step(1, 0, P_ACT, 2'd3, 12'h123);
      // R3 ignored commands
      step(1, 1, P_ACT, 2'd1, 12'h555);
      step(0, 0, P_RD,  2'd0, 12'h011);
      step(0, 0, P_MRS, 2'd0, 12'h031);
      // R5 closed bank
      step(1, 0, P_RD, 2'd1, 12'h010);
      step(1, 0, P_WR, 2'd2, 12'h010);
      // R13 read
      step(1, 0, P_RD, 2'd0, 12'h05A);
      // R8/R9 mode
      step(1, 0, P_MRS, 2'd0, 12'h023);
      step(1, 0, P_MRS, 2'd0, 12'h03F);
      step(1, 0, P_MRS, 2'd0, 12'h035);
      step(1, 0, P_MRS, 2'd0, 12'h037);
      step(1, 0, P_MRS, 2'd0, 12'h03B);
      // R10/R11 write burst of 8 (4 edges), reads across window
      step(1, 0, P_WR, 2'd3, 12'h020);
      step(1, 0, P_RD, 2'd0, 12'h001);
      step(1, 1, P_RD, 2'd0, 12'h001);
      step(1, 0, P_RD, 2'd0, 12'h101);
      step(1, 0, P_RD, 2'd0, 12'h002);
      step(1, 0, P_RD, 2'd0, 12'h003);
      // R12 restart
      step(1, 0, P_WR, 2'd0, 12'h040);
      step(1, 0, P_NOP, 2'd0, 12'h000);
      step(1, 0, P_NOP, 2'd0, 12'h000);
      step(1, 0, P_WR, 2'd3, 12'h041);
      step(1, 0, P_RD, 2'd2, 12'h000);
      step(0, 0, P_NOP, 2'd0, 12'h000);
      step(1, 0, P_NOP, 2'd0, 12'h000);
      step(1, 0, P_NOP, 2'd0, 12'h000);
      // R7 auto precharge
      step(1, 0, P_RD, 2'd0, 12'h17F);
      step(1, 0, P_RD, 2'd0, 12'h07F);
      // R6 precharge
      step(1, 0, P_ACT, 2'd1, 12'hFFF);
      step(1, 0, P_PRE, 2'd3, 12'h000);
      step(1, 0, P_ACT, 2'd2, 12'h800);
      step(1, 0, P_PRE, 2'd0, 12'h400);
      step(1, 0, P_MRS, 2'd0, 12'h032);

      // random traffic
      mv[0] = 12'h031; mv[1] = 12'h032; mv[2] = 12'h03B;
      mv[3] = 12'h037; mv[4] = 12'h03F; mv[5] = 12'h051;
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         bit [11:0] ad;
         bit [1:0]  ba;
         r  = $urandom % 16;
         ba = 2'($urandom);
         ad = 12'($urandom);
         if (($urandom % 4) != 0) ad[8] = 1'b0;
         if (($urandom % 3) != 0) ad[10] = 1'b0;
         case (r)
            0, 1, 2:  step(1, 0, P_ACT, ba, ad);
            3, 4, 15: step(1, 0, P_RD, ba, ad);
            5, 6:     step(1, 0, P_WR, ba, ad);
            7:        step(1, 0, P_PRE, ba, ad);
            8:        step(1, 0, P_REF, ba, ad);
            9:        step(1, 0, P_MRS, ba, (($urandom % 8) == 0) ? mv[3] : mv[$urandom % 6]);
            10:       step(1, 0, P_NOP, ba, ad);
            11:       step(1, 0, P_BST, ba, ad);
            12, 13:   step(1, 1, 3'($urandom), ba, ad);
            default:  step(0, 0, 3'($urandom), ba, ad);
         endcase
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule